// File: doc/BRIEF.md
# Serial Flash SPI Master with Byte FIFOs

This block is a register-mapped SPI master built to drive a serial flash device. Software writes bytes into an 8-entry transmit FIFO and reads received bytes out of an 8-entry receive FIFO over a simple 32-bit register bus. A shift engine takes one FIFO entry at a time and moves it out as a frame on SCK and MOSI while it samples MISO. The engine also drives a single active-low chip select.

The SCK rate comes from a programmable divider. Clock polarity, clock phase, bit order and frame length are all configurable. A direction bit chooses whether received frames are kept or dropped. Three chip-select policies are available: per-frame, held across frames, and never asserted. Held mode lets a flash command, its address and its data bytes share one select window. Two watermark flags report FIFO levels, and a maskable interrupt output is formed from them.

The bus is one cycle per access. Read data is combinational from the byte address. A read strobe on the receive-data register pops one entry at the clock edge.

Top module: `spi_flash_master`

## Requirements
- R1: After reset, cs_n is 1, sck is 0, irq is 0, and a read of the RX data register (byte address 0x4C) returns 0x8000_0000.
- R2: The clock divider register (0x00, low bits) sets the SCK half-period to divider+1 system clocks. A frame of N bits has exactly 2N SCK edges. While no frame is in progress, SCK rests at the polarity bit (bit 0 of 0x04).
- R3: Phase (bit 1 of 0x04) chooses the sampling edge. With phase 0, MISO is sampled and MOSI is stable on the leading (first) edge of each bit. With phase 1, this happens on the trailing edge.
- R4: In the format register (0x40), bits [19:16] give the frame length N (0 or values above 8 mean 8), and the frame carries the low N bits of the TX byte. Bit 2 = 0 sends bit N-1 first. Bit 2 = 1 sends bit 0 first. Bits [1:0] are stored and read back only.
- R5: With format bit 3 = 0 (receive), every finished frame pushes its received bits into the RX FIFO, right-aligned in wire order as set by bit 2.
- R6: With format bit 3 = 1 (transmit), bits shifted in on MISO are dropped and the RX FIFO stays unchanged.
- R7: CS mode (0x18) 0 is auto: cs_n falls before the first SCK edge of each frame and rises one half-period after its last edge.
- R8: CS mode 2 is hold: once a frame starts, cs_n stays low between frames until the mode is written away from 2.
- R9: CS mode 3 is off: cs_n stays 1 even while frames are shifted.
- R10: A read of TX data (0x48) returns bit 31 set while the 8-entry TX FIFO is full. A write to 0x48 while it is full is ignored.
- R11: A read of RX data returns bit 31 set when the RX FIFO is empty. Otherwise it returns the oldest byte in bits [7:0] and pops it.
- R12: Interrupt-pending (0x74) bit 0 is 1 while (TX FIFO count + 1 if a frame is in progress) is strictly below the TX watermark (0x50 bits [15:0]).
- R13: Interrupt-pending bit 1 is 1 while the RX FIFO count is strictly greater than the RX watermark (0x54 bits [15:0]).
- R14: irq is 1 when any bit of interrupt-pending is set with the matching bit of interrupt-enable (0x70 bits [1:0]) also set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 7 | Byte address of the register access |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe (pops RX data when addressed) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from reg_addr |
| sck | output | 1 | SPI serial clock |
| mosi | output | 1 | Serial data to the flash |
| miso | input | 1 | Serial data from the flash |
| cs_n | output | 1 | Active-low chip select |
| irq | output | 1 | Masked watermark interrupt |

## Verification
MISO is looped back to MOSI, so a receive frame returns the byte that was sent. A separate wire monitor rebuilds each frame from the sampling edge. Random bytes are sent across random polarity, phase, bit order and divider settings. The monitor tells a wrong bit order apart from a wrong sampling edge, and the receive path tells a wrong reassembly apart from a wrong wire order. Directed four-bit frames separate the length clamp from the alignment. Bursts in hold, auto and off select modes show the select behaviour across frame gaps. A nine-byte burst at a slow divider fills the transmit FIFO to show the full flag, the dropped write and the watermark boundaries at equality.

// File: rtl/spi_fm_pkg.sv
package spi_fm_pkg;
   localparam int ADDR_W = 7;
   localparam logic [ADDR_W-1:0] OFS_DIV     = 7'h00;
   localparam logic [ADDR_W-1:0] OFS_CLKMODE = 7'h04;
   localparam logic [ADDR_W-1:0] OFS_CSMODE  = 7'h18;
   localparam logic [ADDR_W-1:0] OFS_FMT     = 7'h40;
   localparam logic [ADDR_W-1:0] OFS_TXD     = 7'h48;
   localparam logic [ADDR_W-1:0] OFS_RXD     = 7'h4C;
   localparam logic [ADDR_W-1:0] OFS_TXCTL   = 7'h50;
   localparam logic [ADDR_W-1:0] OFS_RXCTL   = 7'h54;
   localparam logic [ADDR_W-1:0] OFS_IE      = 7'h70;
   localparam logic [ADDR_W-1:0] OFS_IP      = 7'h74;

   typedef enum logic [1:0] {
      CS_AUTO = 2'd0,
      CS_RSVD = 2'd1,
      CS_HOLD = 2'd2,
      CS_OFF  = 2'd3
   } cs_mode_e;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_SHIFT = 2'd1,
      ST_TAIL  = 2'd2
   } shift_st_e;
endpackage

// File: rtl/spi_fm_fifo.sv
module spi_fm_fifo #(
   parameter int W     = 8,
   parameter int DEPTH = 8,
   localparam int AW   = $clog2(DEPTH),
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [W-1:0]  din,
   input  logic          pop,
   output logic [W-1:0]  dout,
   output logic [CW-1:0] count,
   output logic          full,
   output logic          empty
);
   if ((1 << AW) != DEPTH || DEPTH < 2) begin : g_bad_depth
      $error("spi_fm_fifo: DEPTH must be a power of two of at least 2");
   end

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wp, rp;
   logic          do_push, do_pop;

   assign full    = (count == CW'(DEPTH));
   assign empty   = (count == '0);
   assign do_pop  = pop && !empty;
   assign do_push = push && (!full || do_pop);
   assign dout    = mem[rp];

   always_ff @(posedge clk) begin
      if (do_push) mem[wp] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp    <= '0;
         rp    <= '0;
         count <= '0;
      end else begin
         if (do_push) wp <= wp + 1'b1;
         if (do_pop)  rp <= rp + 1'b1;
         count <= count + CW'(do_push) - CW'(do_pop);
      end
   end
endmodule

// File: rtl/spi_fm_shifter.sv
module spi_fm_shifter
   import spi_fm_pkg::*;
#(
   parameter int DW    = 8,
   parameter int DIV_W = 12,
   parameter int LEN_W = 4,
   localparam int NW   = $clog2(DW + 1),
   localparam int EW   = $clog2(2 * DW + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] div,
   input  logic             pol,
   input  logic             pha,
   input  logic             lsb_first,
   input  logic [LEN_W-1:0] frame_len,
   input  logic             start,
   input  logic [DW-1:0]    tx_data,
   output logic             take,
   output logic             busy,
   output logic             sck,
   output logic             mosi,
   input  logic             miso,
   output logic             rx_valid,
   output logic [DW-1:0]    rx_data
);
   if (NW + 1 < EW) begin : g_bad_width
      $error("spi_fm_shifter: edge counter width mismatch");
   end

   shift_st_e        state;
   logic [DIV_W-1:0] divcnt;
   logic [EW-1:0]    edges;
   logic [NW-1:0]    nbits;
   logic [DW-1:0]    txsh, rxsh;
   logic             sck_q, pha_l, lsb_l;
   logic             tick, leading, sample_edge, last_edge;
   logic [NW-1:0]    nbits_new;

   always_comb begin
      if (frame_len == '0 || int'(frame_len) > DW) nbits_new = NW'(DW);
      else                                         nbits_new = NW'(frame_len);
   end

   assign busy        = (state != ST_IDLE);
   assign take        = (state == ST_IDLE) && start;
   assign tick        = busy && (divcnt == div);
   assign leading     = !edges[0];
   assign sample_edge = leading ^ pha_l;
   assign last_edge   = (edges + 1'b1) == EW'({nbits, 1'b0});
   assign sck         = pol ^ sck_q;
   assign mosi        = lsb_l ? txsh[0] : txsh[DW-1];
   assign rx_valid    = (state == ST_TAIL) && tick;
   assign rx_data     = lsb_l ? (rxsh >> (DW - int'(nbits))) : rxsh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         divcnt <= '0;
         edges  <= '0;
         nbits  <= NW'(DW);
         txsh   <= '0;
         rxsh   <= '0;
         sck_q  <= 1'b0;
         pha_l  <= 1'b0;
         lsb_l  <= 1'b0;
      end else begin
         if (!busy || tick) divcnt <= '0;
         else               divcnt <= divcnt + 1'b1;
         unique case (state)
            ST_IDLE: begin
               if (start) begin
                  state <= ST_SHIFT;
                  nbits <= nbits_new;
                  edges <= '0;
                  rxsh  <= '0;
                  pha_l <= pha;
                  lsb_l <= lsb_first;
                  txsh  <= lsb_first ? tx_data
                                     : (tx_data << (DW - int'(nbits_new)));
               end
            end
            ST_SHIFT: begin
               if (tick) begin
                  sck_q <= !sck_q;
                  edges <= edges + 1'b1;
                  if (sample_edge) begin
                     rxsh <= lsb_l ? {miso, rxsh[DW-1:1]} : {rxsh[DW-2:0], miso};
                  end else if (!(pha_l && edges == '0)) begin
                     txsh <= lsb_l ? (txsh >> 1) : (txsh << 1);
                  end
                  if (last_edge) state <= ST_TAIL;
               end
            end
            ST_TAIL: begin
               if (tick) state <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/spi_flash_master.sv
module spi_flash_master
   import spi_fm_pkg::*;
#(
   parameter int FIFO_DEPTH = 8,
   parameter int DW         = 8,
   parameter int DIV_W      = 12,
   parameter int DIV_RESET  = 3,
   localparam int LEN_W     = 4,
   localparam int WM_W      = 16,
   localparam int CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   output logic              sck,
   output logic              mosi,
   input  logic              miso,
   output logic              cs_n,
   output logic              irq
);
   if (DW < 2 || DW > 16) begin : g_bad_dw
      $error("spi_flash_master: DW must lie in 2..16");
   end
   if (DIV_W < 1 || DIV_W > 16) begin : g_bad_div
      $error("spi_flash_master: DIV_W must lie in 1..16");
   end
   if (CNT_W >= WM_W) begin : g_bad_depth
      $error("spi_flash_master: FIFO_DEPTH too large for watermark field");
   end

   logic [DIV_W-1:0] div_q;
   logic             pol_q, pha_q;
   cs_mode_e         csmode;
   logic [1:0]       proto_q;
   logic             lsb_q, dir_tx_q, dir_tx_l;
   logic [LEN_W-1:0] len_q;
   logic [WM_W-1:0]  txwm_q, rxwm_q;
   logic [1:0]       ie_q, ip;
   logic             hold_q;

   logic             tx_push, tx_take, tx_full, tx_empty;
   logic [DW-1:0]    tx_dout;
   logic [CNT_W-1:0] tx_cnt;
   logic             rx_push, rx_pop, rx_full, rx_empty, rx_valid;
   logic [DW-1:0]    rx_dout, rx_frame;
   logic [CNT_W-1:0] rx_cnt;
   logic             busy;
   logic [CNT_W:0]   tx_level;
   logic             wdata_unused;

   assign wdata_unused = ^{reg_wdata[31:20], reg_wdata[15:DIV_W]};

   assign tx_push = reg_wr && (reg_addr == OFS_TXD);
   assign rx_pop  = reg_rd && (reg_addr == OFS_RXD);
   assign rx_push = rx_valid && !dir_tx_l;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_q    <= DIV_W'(DIV_RESET);
         pol_q    <= 1'b0;
         pha_q    <= 1'b0;
         csmode   <= CS_AUTO;
         proto_q  <= '0;
         lsb_q    <= 1'b0;
         dir_tx_q <= 1'b0;
         len_q    <= LEN_W'(DW);
         txwm_q   <= '0;
         rxwm_q   <= '0;
         ie_q     <= '0;
      end else if (reg_wr) begin
         unique case (reg_addr)
            OFS_DIV:     div_q <= reg_wdata[DIV_W-1:0];
            OFS_CLKMODE: {pha_q, pol_q} <= reg_wdata[1:0];
            OFS_CSMODE:  csmode <= cs_mode_e'(reg_wdata[1:0]);
            OFS_FMT: begin
               proto_q  <= reg_wdata[1:0];
               lsb_q    <= reg_wdata[2];
               dir_tx_q <= reg_wdata[3];
               len_q    <= reg_wdata[16 +: LEN_W];
            end
            OFS_TXCTL:   txwm_q <= reg_wdata[WM_W-1:0];
            OFS_RXCTL:   rxwm_q <= reg_wdata[WM_W-1:0];
            OFS_IE:      ie_q   <= reg_wdata[1:0];
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_tx_l <= 1'b0;
         hold_q   <= 1'b0;
      end else begin
         if (tx_take) dir_tx_l <= dir_tx_q;
         if (csmode != CS_HOLD) hold_q <= 1'b0;
         else if (busy)         hold_q <= 1'b1;
      end
   end

   spi_fm_fifo #(.W(DW), .DEPTH(FIFO_DEPTH)) u_txq (
      .clk(clk), .rst_n(rst_n),
      .push(tx_push), .din(reg_wdata[DW-1:0]),
      .pop(tx_take), .dout(tx_dout),
      .count(tx_cnt), .full(tx_full), .empty(tx_empty)
   );

   spi_fm_fifo #(.W(DW), .DEPTH(FIFO_DEPTH)) u_rxq (
      .clk(clk), .rst_n(rst_n),
      .push(rx_push), .din(rx_frame),
      .pop(rx_pop), .dout(rx_dout),
      .count(rx_cnt), .full(rx_full), .empty(rx_empty)
   );

   spi_fm_shifter #(.DW(DW), .DIV_W(DIV_W), .LEN_W(LEN_W)) u_eng (
      .clk(clk), .rst_n(rst_n),
      .div(div_q), .pol(pol_q), .pha(pha_q), .lsb_first(lsb_q),
      .frame_len(len_q), .start(!tx_empty), .tx_data(tx_dout),
      .take(tx_take), .busy(busy),
      .sck(sck), .mosi(mosi), .miso(miso),
      .rx_valid(rx_valid), .rx_data(rx_frame)
   );

   assign cs_n     = !((csmode != CS_OFF) && (busy || hold_q));
   assign tx_level = {1'b0, tx_cnt} + (CNT_W + 1)'(busy);
   assign ip[0]    = WM_W'(tx_level) < txwm_q;
   assign ip[1]    = WM_W'(rx_cnt) > rxwm_q;
   assign irq      = |(ip & ie_q);

   always_comb begin
      reg_rdata = '0;
      unique case (reg_addr)
         OFS_DIV:     reg_rdata[DIV_W-1:0] = div_q;
         OFS_CLKMODE: reg_rdata[1:0] = {pha_q, pol_q};
         OFS_CSMODE:  reg_rdata[1:0] = csmode;
         OFS_FMT:     reg_rdata = {12'd0, len_q, 12'd0, dir_tx_q, lsb_q, proto_q};
         OFS_TXD:     reg_rdata[31] = tx_full;
         OFS_RXD: begin
            reg_rdata[31] = rx_empty;
            if (!rx_empty) reg_rdata[DW-1:0] = rx_dout;
         end
         OFS_TXCTL:   reg_rdata[WM_W-1:0] = txwm_q;
         OFS_RXCTL:   reg_rdata[WM_W-1:0] = rxwm_q;
         OFS_IE:      reg_rdata[1:0] = ie_q;
         OFS_IP:      reg_rdata[1:0] = ip;
         default: ;
      endcase
   end
endmodule

// File: rtl/spi_fm_checker.sv
module spi_fm_checker
   import spi_fm_pkg::*;
#(
   parameter int DEPTH = 8,
   parameter int CW    = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] reg_addr,
   input logic              reg_wr,
   input logic              reg_rd,
   input logic [31:0]       reg_rdata,
   input logic              sck,
   input logic              cs_n,
   input logic              pol,
   input logic [1:0]        csmode,
   input logic              busy,
   input logic              tx_take,
   input logic              dir_tx_l,
   input logic [CW-1:0]     tx_cnt,
   input logic [CW-1:0]     rx_cnt
);
   // R2: SCK rests at the polarity level between frames
   assert_sck_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> sck == pol);

   // R9: off mode never selects the flash
   assert_cs_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
      csmode == CS_OFF |-> cs_n);

   // R8: hold keeps the select low once asserted
   assert_cs_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (csmode == CS_HOLD && $past(csmode == CS_HOLD) && $past(!cs_n)) |-> !cs_n);

   // R10: write on a full TX FIFO leaves it full, and the count never exceeds depth
   assert_tx_full_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == OFS_TXD && tx_cnt == CW'(DEPTH) && !tx_take)
      |=> tx_cnt == CW'(DEPTH));
   assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
      tx_cnt <= CW'(DEPTH) && rx_cnt <= CW'(DEPTH));

   // R11: reading an empty RX FIFO flags bit 31
   assert_rx_empty_flag_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd && reg_addr == OFS_RXD && rx_cnt == '0) |-> reg_rdata[31]);

   // R6: transmit-direction frames never grow the RX FIFO
   assert_tx_dir_discard_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (dir_tx_l && !tx_take) |=> rx_cnt <= $past(rx_cnt));
endmodule

bind spi_flash_master spi_fm_checker #(.DEPTH(FIFO_DEPTH), .CW(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
   .reg_rd(reg_rd), .reg_rdata(reg_rdata), .sck(sck), .cs_n(cs_n),
   .pol(pol_q), .csmode(csmode), .busy(busy), .tx_take(tx_take),
   .dir_tx_l(dir_tx_l), .tx_cnt(tx_cnt), .rx_cnt(rx_cnt)
);

// File: tb/spi_flash_master_tb.sv
`timescale 1ns/1ps
module spi_flash_master_tb;
   import spi_fm_pkg::*;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [6:0]  reg_addr = '0;
   logic        reg_wr = 1'b0, reg_rd = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        sck, mosi, miso, cs_n, irq;

   always #10 clk = !clk;   // 50 MHz
   assign miso = mosi;      // loopback

   spi_flash_master u_dut (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
      .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .sck(sck), .mosi(mosi), .miso(miso), .cs_n(cs_n), .irq(irq)
   );

   int  n_checks = 0, n_fail = 0;
   bit  done = 0;

   // wire monitor
   bit          mon_en = 0;
   bit          c_pol = 0, c_pha = 0;
   int          mon_len = 8;
   int          mon_edges = 0, mon_frames = 0;
   logic [7:0]  mon_sh = '0;
   logic [7:0]  mon_data [16];
   realtime     last_t = 0, min_iv = 1e9, max_iv = 0;
   int          cs_rise = 0, cs_fall = 0;

   always @(posedge sck or negedge sck) begin
      if (mon_en) begin
         if (mon_edges > 0) begin
            if ($realtime - last_t < min_iv) min_iv = $realtime - last_t;
            if ($realtime - last_t > max_iv) max_iv = $realtime - last_t;
         end
         last_t = $realtime;
         if (((sck != c_pol) && !c_pha) || ((sck == c_pol) && c_pha))
            mon_sh = {mon_sh[6:0], mosi};
         mon_edges++;
         if (mon_edges == 2 * mon_len) begin
            if (mon_frames < 16) mon_data[mon_frames] = mon_sh & 8'((1 << mon_len) - 1);
            mon_frames++;
            mon_edges = 0;
            mon_sh = '0;
         end
      end
   end
   always @(posedge cs_n) if (mon_en) cs_rise++;
   always @(negedge cs_n) if (mon_en) cs_fall++;

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(logic [6:0] a, logic [31:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(logic [6:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a; reg_rd = 1'b1;
      #1 d = reg_rdata;
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   function automatic logic [7:0] wire_val(logic [7:0] b, int n, bit lsb);
      logic [7:0] r = '0;
      for (int i = 0; i < n; i++) r[n-1-i] = b[i];
      return lsb ? r : (b & 8'((1 << n) - 1));
   endfunction

   int c_div = 3;
   task automatic cfg(int dv, bit p, bit ph, bit lsb, bit dtx, int len);
      mon_en = 0;
      wr(OFS_DIV, 32'(dv));
      wr(OFS_CLKMODE, {30'd0, ph, p});
      wr(OFS_FMT, {12'd0, 4'(len), 12'd0, dtx, lsb, 2'b00});
      c_div = dv; c_pol = p; c_pha = ph; mon_len = (len == 0 || len > 8) ? 8 : len;
      repeat (2) @(negedge clk);
      mon_edges = 0; mon_frames = 0; mon_sh = '0; cs_rise = 0; cs_fall = 0;
      min_iv = 1e9; max_iv = 0;
      mon_en = 1;
   endtask

   task automatic wait_frames(int n);
      wait (mon_frames >= n);
      repeat (c_div + 6) @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      logic [7:0]  b;
      void'($urandom(32'd2024));
      repeat (3) @(negedge clk);
      check("R1 cs_n", 32'(cs_n), 1);
      check("R1 sck", 32'(sck), 0);
      check("R1 irq", 32'(irq), 0);
      @(negedge clk) rst_n = 1'b1;
      rd(OFS_RXD, d); check("R1 rx empty read", d, 32'h8000_0000);
      rd(OFS_TXD, d); check("R10 tx not full", d, 32'h0);

      // random frames, receive direction, auto select
      for (int it = 0; it < 14; it++) begin
         int dv = $urandom_range(0, 3);
         bit p = 1'($urandom), ph = 1'($urandom), lsb = 1'($urandom);
         int len = (it < 12) ? 8 : 4;
         b = (it < 12) ? 8'($urandom) : 8'hA5;
         if (it == 12) lsb = 0;
         if (it == 13) lsb = 1;
         cfg(dv, p, ph, lsb, 0, len);
         check("R2 idle level", 32'(sck), 32'(p));
         wr(OFS_TXD, {24'd0, b});
         wait_frames(1);
         check("R3/R4 wire bits", 32'(mon_data[0]), 32'(wire_val(b, mon_len, lsb)));
         check("R2 half period min", 32'(int'(min_iv)), 32'((dv + 1) * 20));
         check("R2 half period max", 32'(int'(max_iv)), 32'((dv + 1) * 20));
         check("R2 edge count", 32'(mon_edges), 0);
         check("R2 sck rest", 32'(sck), 32'(p));
         check("R7 cs per frame", 32'(cs_rise), 1);
         rd(OFS_RXD, d);
         check("R5/R11 rx byte", d, 32'(b & 8'((1 << mon_len) - 1)));
      end

      // hold mode: three frames under one select window
      cfg(1, 0, 0, 0, 0, 8);
      wr(OFS_CSMODE, 32'(CS_HOLD));
      wr(OFS_TXD, 32'h9F); wr(OFS_TXD, 32'h12); wr(OFS_TXD, 32'h34);
      wait_frames(3);
      check("R8 held low", 32'(cs_n), 0);
      check("R8 no rise", 32'(cs_rise), 0);
      wr(OFS_RXCTL, 32'd2);
      rd(OFS_IP, d); check("R13 rx above wm", d & 32'h2, 32'h2);
      wr(OFS_IE, 32'h2);
      @(negedge clk) check("R14 irq rx", 32'(irq), 1);
      wr(OFS_IE, 32'h1);
      @(negedge clk) check("R14 irq masked", 32'(irq), 0);
      wr(OFS_RXCTL, 32'd3);
      rd(OFS_IP, d); check("R13 rx equal wm", d & 32'h2, 32'h0);
      wr(OFS_CSMODE, 32'(CS_AUTO));
      repeat (2) @(negedge clk);
      check("R8 released", 32'(cs_n), 1);
      rd(OFS_RXD, d); check("R11 pop 1", d, 32'h9F);
      rd(OFS_RXD, d); check("R11 pop 2", d, 32'h12);
      rd(OFS_RXD, d); check("R11 pop 3", d, 32'h34);
      rd(OFS_RXD, d); check("R11 drained", d, 32'h8000_0000);

      // auto mode: one select window per frame
      cfg(0, 1, 1, 0, 0, 8);
      wr(OFS_TXD, 32'h11); wr(OFS_TXD, 32'h22); wr(OFS_TXD, 32'h33);
      wait_frames(3);
      check("R7 three windows", 32'(cs_rise), 3);
      for (int i = 0; i < 3; i++) rd(OFS_RXD, d);

      // off mode, transmit direction
      cfg(0, 0, 0, 0, 1, 8);
      wr(OFS_CSMODE, 32'(CS_OFF));
      wr(OFS_TXD, 32'h5A);
      wait_frames(1);
      check("R9 never selected", 32'(cs_fall), 0);
      check("R9 frame still sent", 32'(mon_data[0]), 32'h5A);
      wr(OFS_CSMODE, 32'(CS_AUTO));
      rd(OFS_RXD, d); check("R6 rx untouched", d, 32'h8000_0000);

      // TX full, dropped write, watermarks
      cfg(40, 0, 0, 0, 1, 8);
      wr(OFS_TXCTL, 32'd1);
      for (int i = 0; i < 9; i++) wr(OFS_TXD, 32'(8'h40 + i));
      rd(OFS_TXD, d); check("R10 full flag", d, 32'h8000_0000);
      wr(OFS_TXD, 32'hEE);
      rd(OFS_IP, d); check("R12 busy above wm", d & 32'h1, 32'h0);
      wr(OFS_TXCTL, 32'd9);
      rd(OFS_IP, d); check("R12 level equal wm", d & 32'h1, 32'h0);
      wr(OFS_TXCTL, 32'd10);
      rd(OFS_IP, d); check("R12 level below wm", d & 32'h1, 32'h1);
      wr(OFS_TXCTL, 32'd1);
      wait_frames(9);
      repeat (700) @(negedge clk);
      check("R10 frame count", 32'(mon_frames), 9);
      for (int i = 0; i < 9; i++)
         check("R10 frame order", 32'(mon_data[i]), 32'(8'h40 + i));
      rd(OFS_IP, d); check("R12 drained idle", d & 32'h1, 32'h1);
      rd(OFS_RXD, d); check("R6 tx dir discard", d, 32'h8000_0000);
      rd(OFS_FMT, d); check("R4 format readback", d, 32'h0008_0008);

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end
endmodule